// File: doc/BRIEF.md
# DRAM Start-Up and Refresh Sequencer

This block runs from a system clock of known frequency and manages an asynchronous DRAM from power-up onward. After reset it holds the row strobe inactive for a timed start-up pause. It then drives a train of row-only dummy cycles on its own, because no access is allowed during start-up. When those cycles are done it raises `initDone`. From then on it schedules refreshes evenly, so that every row of the part is refreshed inside the retention window.

Each refresh is a column-strobe-first cycle. The device steps its own row counter, so the block never drives an address. The block shares the strobes with an access controller. It asks for the bus on `refReq` and drives `rasN`/`casN` only after it sees `refGrant`. When the controller keeps the bus for a long burst, pending refreshes are counted up to a small bound and then issued back to back. A tick that arrives while the count is already at the bound sets a sticky error flag.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `rasN` and `casN` are 1 and `refReq`, `initDone` and `pendErr` are 0.
- R2: After reset is released, `rasN` stays 1 for at least PAUSE_US microseconds (25000 clocks by default).
- R3: Before `initDone` rises, exactly INIT_PULSES (8) pulses appear on `rasN`, each low for exactly RAS_CYC clocks (7 by default), and `casN` stays 1 throughout.
- R4: Between two `rasN` low pulses, `rasN` is high for at least PRE_CYC clocks, the larger of the row and column precharge times (4 by default).
- R5: `refReq` is 0 until `initDone` is 1. Once `initDone` is 1 it stays 1 until reset.
- R6: The first `refReq` rises exactly INTERVAL_CYC clocks after `initDone` rises. INTERVAL_CYC is the window of WINDOW_US divided by ROW_COUNT, rounded down to clocks (1953 by default). While the grant is held, successive refreshes start exactly INTERVAL_CYC clocks apart.
- R7: Before `initDone`, `refGrant` has no effect. After `initDone`, neither strobe falls unless `refGrant` was 1 while `refReq` was 1.
- R8: In a refresh cycle, `casN` falls exactly LEAD_CYC clocks (2 by default) before `rasN` falls. `rasN` is then low for exactly RAS_CYC clocks, and both strobes rise on the same clock.
- R9: After a refresh, both strobes stay high for at least PRE_CYC clocks before the next falling edge.
- R10: If k refresh ticks (k ≤ PEND_MAX, default 4) arrive while the grant is withheld, granting the bus gives exactly k refresh cycles back to back, and then `refReq` returns to 0.
- R11: A tick that arrives while PEND_MAX refreshes are already pending is lost. It sets `pendErr`, which stays 1 until reset, and the later grant still gives exactly PEND_MAX refreshes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refGrant | input | 1 | Access controller hands the strobes to this block; held while `refReq` is 1 |
| refReq | output | 1 | At least one refresh is pending or running |
| rasN | output | 1 | Row strobe, active low, registered |
| casN | output | 1 | Column strobe, active low, registered |
| initDone | output | 1 | Start-up pause and dummy cycles are complete |
| pendErr | output | 1 | Sticky: a refresh tick was lost at the pending bound |

## Verification
The hardest state to reach from the ports is a saturated pending counter, and in particular a tick that lands while the counter is already full. The stimulus gets there by withholding the grant for a chosen number of refresh intervals. It counts whole intervals from a visible rise of `refReq` and places the grant in the middle of an interval, so no tick lands at the same moment as the grant. Withholding for more intervals than the bound drives the overflow. The number of column-strobe falls that follow shows both the accumulated count and the saturation.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_INIT_LOW,
    ST_INIT_HIGH,
    ST_IDLE,
    ST_CAS_LEAD,
    ST_CBR_LOW,
    ST_PRECHARGE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldLead;
    logic ldRasLow;
    logic ldPre;
    logic incInit;
    logic setDone;
    logic decPend;
    logic rasLow;
    logic casLow;
  } seqStrobes_t;

  // status from datapath to control
  typedef struct packed {
    logic phaseZero;
    logic initLast;
    logic pendNz;
  } seqStatus_t;

  // nanoseconds to clocks, rounded up, never below one
  function automatic int nsToCycles(longint ns, longint clkKhz);
    longint c;
    c = (ns * clkKhz + 64'd999999) / 64'd1000000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  // refresh spacing in clocks, rounded down so the window is never exceeded
  function automatic int refreshSpacing(longint windowUs, longint rows, longint clkKhz);
    longint c;
    c = (windowUs * clkKhz) / (64'd1000 * rows);
    if (c < 2) c = 2;
    return int'(c);
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refseq_ctrl.sv
module refseq_ctrl
  import dram_refresh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        refGrant,
  input  seqStatus_t  stat,
  output seqStrobes_t strb
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PAUSE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_PAUSE: begin
        if (stat.phaseZero) begin
          nextState     = ST_INIT_LOW;
          strb.ldRasLow = 1'b1;
        end
      end
      ST_INIT_LOW: begin
        strb.rasLow = 1'b1;
        if (stat.phaseZero) begin
          nextState  = ST_INIT_HIGH;
          strb.ldPre = 1'b1;
        end
      end
      ST_INIT_HIGH: begin
        if (stat.phaseZero) begin
          if (stat.initLast) begin
            nextState    = ST_IDLE;
            strb.setDone = 1'b1;
          end else begin
            nextState     = ST_INIT_LOW;
            strb.ldRasLow = 1'b1;
            strb.incInit  = 1'b1;
          end
        end
      end
      ST_IDLE: begin
        if (stat.pendNz && refGrant) begin
          nextState   = ST_CAS_LEAD;
          strb.ldLead = 1'b1;
        end
      end
      ST_CAS_LEAD: begin
        strb.casLow = 1'b1;
        if (stat.phaseZero) begin
          nextState     = ST_CBR_LOW;
          strb.ldRasLow = 1'b1;
        end
      end
      ST_CBR_LOW: begin
        strb.casLow = 1'b1;
        strb.rasLow = 1'b1;
        if (stat.phaseZero) begin
          nextState  = ST_PRECHARGE;
          strb.ldPre = 1'b1;
        end
      end
      ST_PRECHARGE: begin
        if (stat.phaseZero) begin
          nextState    = ST_IDLE;
          strb.decPend = 1'b1;
        end
      end
      default: nextState = ST_PAUSE;
    endcase
  end

endmodule

// File: rtl/refseq_dpath.sv
module refseq_dpath
  import dram_refresh_pkg::*;
#(
  parameter int PAUSE_CYC    = 25000,
  parameter int RAS_CYC      = 7,
  parameter int PRE_CYC      = 4,
  parameter int LEAD_CYC     = 2,
  parameter int INIT_PULSES  = 8,
  parameter int INTERVAL_CYC = 1953,
  parameter int PEND_MAX     = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobes_t strb,
  output seqStatus_t  stat,
  output logic        refReq,
  output logic        rasN,
  output logic        casN,
  output logic        initDone,
  output logic        pendErr
);

  localparam int PH_W = $clog2(maxOf(PAUSE_CYC, maxOf(RAS_CYC, maxOf(PRE_CYC, LEAD_CYC))) + 1);
  localparam int IN_W = $clog2(INIT_PULSES + 1);
  localparam int IV_W = $clog2(INTERVAL_CYC + 1);
  localparam int PD_W = $clog2(PEND_MAX + 1);

  logic [PH_W-1:0] phaseCnt;
  logic [IN_W-1:0] initCnt;
  logic [IV_W-1:0] ivCnt;
  logic [PD_W-1:0] pendCnt, pendNext;
  logic            doneQ, errQ, tick, overflow;

  // phase timer: every state lasts (loaded value + 1) clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phaseCnt <= PH_W'(PAUSE_CYC - 1);
    else if (strb.ldLead)   phaseCnt <= PH_W'(LEAD_CYC - 1);
    else if (strb.ldRasLow) phaseCnt <= PH_W'(RAS_CYC - 1);
    else if (strb.ldPre)    phaseCnt <= PH_W'(PRE_CYC - 1);
    else if (phaseCnt != '0) phaseCnt <= phaseCnt - 1'b1;
  end

  // start-up pulse counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             initCnt <= '0;
    else if (strb.incInit) initCnt <= initCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             doneQ <= 1'b0;
    else if (strb.setDone) doneQ <= 1'b1;
  end

  // refresh cadence timer, free-running once start-up is complete
  assign tick = doneQ && (ivCnt == IV_W'(INTERVAL_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      ivCnt <= '0;
    else if (tick)  ivCnt <= '0;
    else if (doneQ) ivCnt <= ivCnt + 1'b1;
  end

  // pending refresh count, saturating at the bound
  always_comb begin
    pendNext = pendCnt;
    overflow = 1'b0;
    unique case ({tick, strb.decPend})
      2'b10: begin
        if (pendCnt == PD_W'(PEND_MAX)) overflow = 1'b1;
        else                            pendNext = pendCnt + 1'b1;
      end
      2'b01:   pendNext = pendCnt - 1'b1;
      default: pendNext = pendCnt;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCnt <= '0;
      errQ    <= 1'b0;
    end else begin
      pendCnt <= pendNext;
      errQ    <= errQ | overflow;
    end
  end

  // registered strobes toward the device
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasN <= 1'b1;
      casN <= 1'b1;
    end else begin
      rasN <= ~strb.rasLow;
      casN <= ~strb.casLow;
    end
  end

  assign stat.phaseZero = (phaseCnt == '0);
  assign stat.initLast  = (initCnt == IN_W'(INIT_PULSES - 1));
  assign stat.pendNz    = (pendCnt != '0);

  assign refReq   = (pendCnt != '0);
  assign initDone = doneQ;
  assign pendErr  = errQ;

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int CLK_KHZ     = 125000,
  parameter int PAUSE_US    = 200,
  parameter int INIT_PULSES = 8,
  parameter int ROW_COUNT   = 1024,
  parameter int WINDOW_US   = 16000,
  parameter int RAS_MIN_NS  = 50,
  parameter int RP_MIN_NS   = 30,
  parameter int CP_MIN_NS   = 10,
  parameter int LEAD_NS     = 10,
  parameter int PEND_MAX    = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGrant,
  output logic refReq,
  output logic rasN,
  output logic casN,
  output logic initDone,
  output logic pendErr
);

  localparam int PAUSE_CYC    = nsToCycles(longint'(PAUSE_US) * 1000, CLK_KHZ);
  localparam int RAS_CYC      = nsToCycles(RAS_MIN_NS, CLK_KHZ);
  localparam int RP_CYC       = nsToCycles(RP_MIN_NS, CLK_KHZ);
  localparam int CP_CYC       = nsToCycles(CP_MIN_NS, CLK_KHZ);
  localparam int PRE_CYC      = maxOf(RP_CYC, CP_CYC);
  localparam int LEAD_CYC     = nsToCycles(LEAD_NS, CLK_KHZ);
  localparam int INTERVAL_CYC = refreshSpacing(WINDOW_US, ROW_COUNT, CLK_KHZ);

  seqStrobes_t strb;
  seqStatus_t  stat;

  refseq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .refGrant (refGrant),
    .stat     (stat),
    .strb     (strb)
  );

  refseq_dpath #(
    .PAUSE_CYC    (PAUSE_CYC),
    .RAS_CYC      (RAS_CYC),
    .PRE_CYC      (PRE_CYC),
    .LEAD_CYC     (LEAD_CYC),
    .INIT_PULSES  (INIT_PULSES),
    .INTERVAL_CYC (INTERVAL_CYC),
    .PEND_MAX     (PEND_MAX)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .stat     (stat),
    .refReq   (refReq),
    .rasN     (rasN),
    .casN     (casN),
    .initDone (initDone),
    .pendErr  (pendErr)
  );

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int RAS_CYC = 7,
  parameter int PRE_CYC = 4
) (
  input logic clk,
  input logic rstN,
  input logic refGrant,
  input logic refReq,
  input logic rasN,
  input logic casN,
  input logic initDone,
  input logic pendErr
);

  logic [7:0] lowCnt, highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      highCnt <= '0;
    end else begin
      lowCnt  <= rasN ? 8'd0 : ((lowCnt == 8'hFF) ? lowCnt : lowCnt + 8'd1);
      highCnt <= !rasN ? 8'd0 : ((highCnt == 8'hFF) ? highCnt : highCnt + 8'd1);
    end
  end

  AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> !refReq); // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone); // R5

  AST_INIT_CAS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> casN); // R3

  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (lowCnt == 8'(RAS_CYC))); // R8

  AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (highCnt >= 8'(PRE_CYC))); // R9

  AST_CAS_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (initDone && $fell(rasN)) |-> !$past(casN)); // R8

  AST_GRANTED_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> $past(refGrant, 2)); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    pendErr |=> pendErr); // R11

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .RAS_CYC (RAS_CYC),
  .PRE_CYC (PRE_CYC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .refGrant (refGrant),
  .refReq   (refReq),
  .rasN     (rasN),
  .casN     (casN),
  .initDone (initDone),
  .pendErr  (pendErr)
);

// File: tb/tb_dram_refresh_seq.sv
`timescale 1ns/1ps
module tb_dram_refresh_seq;

  // expected timing at an 8 ns clock, derived from the requirements
  localparam int PAUSE    = 200000 / 8;        // 200 us
  localparam int INTERVAL = (16000000 / 1024) / 8; // 15625 ns per row, rounded down
  localparam int RAS      = 7;                 // 50 ns rounded up
  localparam int PRE      = 4;                 // max(30 ns, 10 ns) rounded up
  localparam int LEAD     = 2;                 // 10 ns rounded up
  localparam int NVEC     = 5;
  // {intervals with grant withheld, expected refreshes, expected error flag}
  localparam int VEC [NVEC][3] = '{
    '{1, 1, 0}, '{3, 3, 0}, '{2, 2, 0}, '{4, 4, 0}, '{6, 4, 1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGrant = 1'b0;
  logic refReq, rasN, casN, initDone, pendErr;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dram_refresh_seq dut (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .refReq(refReq),
    .rasN(rasN), .casN(casN), .initDone(initDone), .pendErr(pendErr)
  );

  // strobe monitor, sampled on falling clock edges
  int cyc = 0, lowRun = 0, highRun = 0, casRun = 0;
  int rasFalls = 0, initFalls = 0, casFalls = 0;
  int widthViol = 0, gapViol = 0, leadViol = 0, riseViol = 0;
  int earlyReq = 0, initCasLow = 0, lastCasCyc = 0, casGap = 0;
  logic prevRas = 1'b1, prevCas = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      lowRun = 0; highRun = 0; casRun = 0; prevRas = 1'b1; prevCas = 1'b1;
    end else begin
      if (prevRas && !rasN) begin
        rasFalls++;
        if (!initDone) initFalls++;
        if (rasFalls > 1 && highRun < PRE) gapViol++;
        if (initDone && casRun != LEAD) leadViol++;
      end
      if (!prevRas && rasN) begin
        if (lowRun != RAS) widthViol++;
        if (!casN) riseViol++;
      end
      if (prevCas && !casN) begin
        casFalls++;
        casGap = cyc - lastCasCyc;
        lastCasCyc = cyc;
      end
      if (!initDone && refReq) earlyReq++;
      if (!initDone && !casN) initCasLow++;
      lowRun  = rasN ? 0 : lowRun + 1;
      highRun = rasN ? highRun + 1 : 0;
      casRun  = casN ? 0 : casRun + 1;
      prevRas = rasN;
      prevCas = casN;
    end
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int cnt;
    int base;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 rasN", int'(rasN), 1);
    check("R1 casN", int'(casN), 1);
    check("R1 refReq/initDone/pendErr", int'({refReq, initDone, pendErr}), 0);

    // grant held during start-up must have no effect (R7)
    refGrant = 1'b1;
    rstN = 1'b1;
    cnt = 0;
    while (rasN) begin @(negedge clk); cnt++; end
    check("R2 pause length", int'(cnt >= PAUSE), 1);

    while (!initDone) @(negedge clk);
    check("R3 start-up pulses", initFalls, 8);
    check("R3 start-up casN idle", initCasLow, 0);
    check("R4 start-up gaps", gapViol, 0);
    check("R5 no request before start-up done", earlyReq, 0);
    refGrant = 1'b0;

    cnt = 0;
    while (!refReq) begin @(negedge clk); cnt++; end
    check("R6 first request delay", cnt, INTERVAL);

    base = casFalls;
    repeat (100) @(negedge clk);
    check("R7 no strobes without grant", casFalls - base, 0);
    check("R7 rasN idle without grant", int'(rasN), 1);

    // accumulation vectors
    for (int v = 0; v < NVEC; v++) begin
      while (!refReq) @(negedge clk);
      repeat ((VEC[v][0] - 1) * INTERVAL + INTERVAL / 2) @(negedge clk);
      base = casFalls;
      refGrant = 1'b1;
      while (refReq) @(negedge clk);
      repeat (20) @(negedge clk);
      refGrant = 1'b0;
      check($sformatf("R10 burst after %0d intervals", VEC[v][0]), casFalls - base, VEC[v][1]);
      check($sformatf("R11 error flag after %0d intervals", VEC[v][0]), int'(pendErr), VEC[v][2]);
    end

    // steady cadence with the grant held; error stays set
    base = casFalls;
    refGrant = 1'b1;
    repeat (2 * INTERVAL) @(negedge clk);
    check("R6 refreshes in two intervals", casFalls - base, 2);
    check("R6 refresh spacing", casGap, INTERVAL);
    check("R11 error sticky", int'(pendErr), 1);
    refGrant = 1'b0;

    check("R8 cas lead", leadViol, 0);
    check("R8 ras low width", widthViol, 0);
    check("R8 strobes rise together", riseViol, 0);
    check("R9 precharge gap", gapViol, 0);

    // reset mid-run returns to the idle state (R1)
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset clears outputs", int'({refReq, initDone, pendErr}), 0);
    check("R1 strobes high in reset", int'({rasN, casN}), 3);
    finishRun();
  end

endmodule